// File: doc/BRIEF.md
# Status register read-and-clear unit

This block holds a processor's 32-bit machine status register and carries out a combined read-and-clear operation on it. When a recognised operation arrives, the unit returns the register's value as it stood before the operation, for writeback to a destination register. It then clears every status bit whose matching bit in a 15-bit immediate is 1 and leaves all other bits as they are. The carry bit is cleared at once. All other cleared bits are held in a one-entry pending slot and land one cycle later.

When the unit is built with memory management, the operation is privileged while the user-mode bit is set. In that case any immediate other than the carry-only mask raises an exception pulse and loads a 5-bit exception code. No value is returned and the register is left as it was. A separate status write port represents the rest of the pipeline writing the whole register. The interrupt-enable output is forwarded from the pending slot, so the processor sees interrupts blocked from the cycle right after a clear.

Bits are numbered with the most significant bit at position 0, so position 31 is the least significant bit. Carry sits at position 29 (vector index 2), interrupt enable at position 30 (index 1), user mode at position 17 (index 14) and virtual mode at position 18 (index 13).

Top module: `srclr_unit`

## Requirements
- R1: A synchronous active-high reset clears the status register, the pending slot, the read valid, the exception pulse and the exception code to zero. An in-flight delayed clear is discarded.
- R2: An operation is recognised when op_valid is 1, the major opcode is 6'b100101 and the function field is 6'b100010. One cycle later rd_valid pulses and rd_data holds the status value from before the operation.
- R3: A status bit at vector index i (i < 15) is cleared when imm[i] is 1 and the bit is clearable. Bits whose immediate bit is 0 keep their value. Vector indices 15 to 31 are never changed by the operation.
- R4: A cleared carry (index 2, imm value 0x4) shows on carry_o in the cycle after the operation. Other cleared bits land one cycle after that. A read issued in the very next cycle therefore returns carry already cleared and the other bits not yet cleared.
- R5: ie_o drops in the cycle after an operation that clears interrupt enable (index 1), even though the register bit itself lands a cycle later.
- R6: With memory management enabled and user mode set (index 14), any immediate other than 0x4 causes a privilege fault. exc_pulse is 1 one cycle later, exc_code becomes 5'b00111 and keeps that value, rd_valid stays 0 and the status register is not changed. An immediate of 0x4 is allowed in user mode.
- R7: With memory management enabled, all 15 immediate bits may clear (indices 0 to 14). Without it, imm[14] is ignored so user mode is never cleared, and no privilege check is made.
- R8: With the status-instruction build parameter off, no operation is ever recognised: no read valid, no exception, no change of state.
- R9: An op_valid with a wrong major opcode or function field has no effect.
- R10: A status write sets the register to wr_data in the next cycle and takes priority over a delayed clear that lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle operation strobe |
| op_major | input | 6 | Major opcode field |
| op_func | input | 6 | Function field |
| imm | input | 15 | Clear mask, bit i addresses vector index i |
| wr_en | input | 1 | Whole-register status write strobe |
| wr_data | input | 32 | Status write value |
| rd_valid | output | 1 | Read value valid pulse |
| rd_data | output | 32 | Status value from before the operation |
| exc_pulse | output | 1 | Privilege fault pulse |
| exc_code | output | 5 | Exception code, held until the next fault or reset |
| carry_o | output | 1 | Current carry bit |
| ie_o | output | 1 | Interrupt enable, including a pending clear |

## Verification
Two pairs of events can meet in one cycle. The delayed clear from one operation can land together with a second operation issued back to back, or together with a status write. The bench provokes the first by holding op_valid for two cycles. It expects the second read to show carry cleared but interrupt enable still set, and a read after that to show both cleared. It provokes the second by writing interrupt enable back in the cycle after a clear. It judges the result by ie_o being low in that cycle and high in the next, and by a later read returning the written value.

// File: rtl/srclr_pkg.sv
package srclr_pkg;
    localparam int SR_W   = 32;
    localparam int IMM_W  = 15;
    localparam int CODE_W = 5;

    localparam int CARRY_IX = 2;
    localparam int IE_IX    = 1;
    localparam int VM_IX    = 13;
    localparam int UM_IX    = 14;

    localparam logic [5:0]        MAJOR_OP   = 6'b100101;
    localparam logic [5:0]        FUNC_CLR   = 6'b100010;
    localparam logic [IMM_W-1:0]  CARRY_ONLY = 15'h0004;
    localparam logic [CODE_W-1:0] CODE_PRIV  = 5'b00111;

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic              pend;
        logic [SR_W-1:0]   pend_mask;
        logic [SR_W-1:0]   rd_data;
        logic              rd_valid;
        logic              exc;
        logic [CODE_W-1:0] exc_code;
    } srclr_state_t;
endpackage

// File: rtl/srclr_decode.sv
module srclr_decode
    import srclr_pkg::*;
#(
    parameter bit MMU_EN   = 1'b1,
    parameter bit INSTR_EN = 1'b1
) (
    input  logic             op_valid,
    input  logic [5:0]       op_major,
    input  logic [5:0]       op_func,
    input  logic [IMM_W-1:0] imm,
    input  logic             user_mode,
    output logic             hit,
    output logic             priv_fault
);
    logic match;

    always_comb begin
        match      = op_valid && (op_major == MAJOR_OP) && (op_func == FUNC_CLR);
        hit        = INSTR_EN && match;
        priv_fault = hit && MMU_EN && user_mode && (imm != CARRY_ONLY);
    end
endmodule

// File: rtl/srclr_mask.sv
module srclr_mask
    import srclr_pkg::*;
#(
    parameter bit MMU_EN = 1'b1
) (
    input  logic [IMM_W-1:0] imm,
    output logic [SR_W-1:0]  clr_mask
);
    localparam int CLR_BITS = MMU_EN ? IMM_W : IMM_W - 1;

    for (genvar i = 0; i < SR_W; i++) begin : g_bit
        if (i < CLR_BITS) begin : g_live
            assign clr_mask[i] = imm[i];
        end else begin : g_fixed
            assign clr_mask[i] = 1'b0;
        end
    end
endmodule

// File: rtl/srclr_unit.sv
module srclr_unit
    import srclr_pkg::*;
#(
    parameter bit MMU_EN   = 1'b1,
    parameter bit INSTR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [5:0]        op_major,
    input  logic [5:0]        op_func,
    input  logic [IMM_W-1:0]  imm,
    input  logic              wr_en,
    input  logic [SR_W-1:0]   wr_data,
    output logic              rd_valid,
    output logic [SR_W-1:0]   rd_data,
    output logic              exc_pulse,
    output logic [CODE_W-1:0] exc_code,
    output logic              carry_o,
    output logic              ie_o
);
    localparam logic [SR_W-1:0] CARRY_BIT = SR_W'(1) << CARRY_IX;

    srclr_state_t    st_q, st_d;
    logic            hit, priv_fault;
    logic [SR_W-1:0] clr_mask;
    logic [SR_W-1:0] base;

    srclr_decode #(.MMU_EN(MMU_EN), .INSTR_EN(INSTR_EN)) u_decode (
        .op_valid   (op_valid),
        .op_major   (op_major),
        .op_func    (op_func),
        .imm        (imm),
        .user_mode  (st_q.sr[UM_IX]),
        .hit        (hit),
        .priv_fault (priv_fault)
    );

    srclr_mask #(.MMU_EN(MMU_EN)) u_mask (
        .imm      (imm),
        .clr_mask (clr_mask)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rd_valid  = 1'b0;
        st_d.exc       = 1'b0;
        st_d.pend      = 1'b0;
        st_d.pend_mask = '0;
        base = st_q.pend ? (st_q.sr & ~st_q.pend_mask) : st_q.sr;
        if (wr_en) begin
            base = wr_data;
        end
        if (hit) begin
            if (priv_fault) begin
                st_d.exc      = 1'b1;
                st_d.exc_code = CODE_PRIV;
            end else begin
                st_d.rd_data   = st_q.sr;
                st_d.rd_valid  = 1'b1;
                base           = base & ~(clr_mask & CARRY_BIT);
                st_d.pend_mask = clr_mask & ~CARRY_BIT;
                st_d.pend      = |(clr_mask & ~CARRY_BIT);
            end
        end
        st_d.sr = base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign exc_pulse = st_q.exc;
    assign exc_code  = st_q.exc_code;
    assign carry_o   = st_q.sr[CARRY_IX];
    assign ie_o      = st_q.sr[IE_IX] & ~(st_q.pend & st_q.pend_mask[IE_IX]);

    // R2: an accepted, non-faulting operation returns a value next cycle
    a_r2_read_back: assert property (@(posedge clk) disable iff (rst)
        (hit && !priv_fault) |=> rd_valid);

    // R4: carry clear is visible in the very next cycle
    a_r4_carry_now: assert property (@(posedge clk) disable iff (rst)
        (hit && !priv_fault && clr_mask[CARRY_IX] && !wr_en) |=> !carry_o);

    // R5: interrupts are blocked from the next cycle on
    a_r5_ie_blocked: assert property (@(posedge clk) disable iff (rst)
        (hit && !priv_fault && clr_mask[IE_IX]) |=> !ie_o);

    // R6: a fault returns no value and leaves the register alone
    a_r6_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        exc_pulse |-> !rd_valid);
    a_r6_fault_stable: assert property (@(posedge clk) disable iff (rst)
        (priv_fault && !wr_en && !st_q.pend) |=> $stable(st_q.sr));

    // R3: the operation never touches the upper status bits
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (st_q.sr[SR_W-1:IMM_W] == $past(st_q.sr[SR_W-1:IMM_W])));
endmodule

// File: tb/test_srclr_unit.sv
module test_srclr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [5:0]  op_major, op_func;
    logic [14:0] imm;
    logic        wr_en;
    logic [31:0] wr_data;

    logic        a_rv, b_rv, c_rv, a_ex, b_ex, c_ex, a_cy, b_cy, c_cy, a_ie, b_ie, c_ie;
    logic [31:0] a_rd, b_rd, c_rd;
    logic [4:0]  a_cd, b_cd, c_cd;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ma, mb, mc;

    always #4 clk = ~clk;

    srclr_unit #(.MMU_EN(1'b1), .INSTR_EN(1'b1)) i_srclr_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_major(op_major), .op_func(op_func),
        .imm(imm), .wr_en(wr_en), .wr_data(wr_data), .rd_valid(a_rv), .rd_data(a_rd),
        .exc_pulse(a_ex), .exc_code(a_cd), .carry_o(a_cy), .ie_o(a_ie));

    srclr_unit #(.MMU_EN(1'b0), .INSTR_EN(1'b1)) i_srclr_unit_nommu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_major(op_major), .op_func(op_func),
        .imm(imm), .wr_en(wr_en), .wr_data(wr_data), .rd_valid(b_rv), .rd_data(b_rd),
        .exc_pulse(b_ex), .exc_code(b_cd), .carry_o(b_cy), .ie_o(b_ie));

    srclr_unit #(.MMU_EN(1'b1), .INSTR_EN(1'b0)) i_srclr_unit_off (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_major(op_major), .op_func(op_func),
        .imm(imm), .wr_en(wr_en), .wr_data(wr_data), .rd_valid(c_rv), .rd_data(c_rd),
        .exc_pulse(c_ex), .exc_code(c_cd), .carry_o(c_cy), .ie_o(c_ie));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] clr_apply(input logic [31:0] sr, input logic [14:0] m,
                                              input bit mmu);
        logic [14:0] k = mmu ? m : {1'b0, m[13:0]};
        return sr & ~{17'b0, k};
    endfunction

    task automatic idle_inputs();
        op_valid = 1'b0; op_major = 6'b100101; op_func = 6'b100010;
        imm = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ma = d; mb = d; mc = d;
        check("R10 write carry A", 32'(a_cy), 32'(d[2]));
        check("R10 write ie B", 32'(b_ie), 32'(d[1]));
        @(negedge clk);
    endtask

    task automatic do_op(input logic [14:0] m, input logic [5:0] maj, input logic [5:0] fn);
        bit hit, exa;
        logic [31:0] pa, pb, pc;
        op_valid = 1'b1; op_major = maj; op_func = fn; imm = m;
        hit = (maj == 6'b100101) && (fn == 6'b100010);
        exa = hit && ma[14] && (m != 15'h0004);
        pa = ma; pb = mb; pc = mc;
        if (hit && !exa) ma = clr_apply(ma, m, 1'b1);
        if (hit) mb = clr_apply(mb, m, 1'b0);
        @(negedge clk);
        op_valid = 1'b0;
        check(hit ? "R2 rd_valid A" : "R9 rd_valid A", 32'(a_rv), 32'(hit && !exa));
        if (hit && !exa) check("R2 R3 rd_data A", a_rd, pa);
        check("R6 exc A", 32'(a_ex), 32'(exa));
        if (exa) check("R6 code A", 32'(a_cd), 32'h7);
        check("R4 carry A", 32'(a_cy), 32'(ma[2]));
        check("R5 ie A", 32'(a_ie), 32'(ma[1]));
        check(hit ? "R7 rd_valid B" : "R9 rd_valid B", 32'(b_rv), 32'(hit));
        if (hit) check("R7 rd_data B", b_rd, pb);
        check("R7 no exc B", 32'(b_ex), 32'h0);
        check("R4 carry B", 32'(b_cy), 32'(mb[2]));
        check("R8 off C", {30'b0, c_rv, c_ex}, 32'h0);
        check("R8 carry C", 32'(c_cy), 32'(pc[2]));
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        ma = '0; mb = '0; mc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs A", {a_rv, a_ex, a_cy, a_ie, 3'b0, a_cd}, 32'h0);
        check("R1 reset outputs B", {b_rv, b_ex, b_cy, b_ie}, 32'h0);
        do_op(15'h0000, 6'b100101, 6'b100010);

        // R4 back-to-back: second read sees carry cleared, ie not yet
        do_write(32'h0000_0006);
        op_valid = 1'b1; imm = 15'h0006;
        @(negedge clk);
        check("R5 ie forwarded A", 32'(a_ie), 32'h0);
        check("R4 carry now A", 32'(a_cy), 32'h0);
        imm = 15'h0000;
        @(negedge clk);
        op_valid = 1'b0;
        check("R4 stale read A", a_rd, 32'h0000_0002);
        check("R4 stale read B", b_rd, 32'h0000_0002);
        @(negedge clk);
        ma = 32'h0; mb = 32'h0;
        do_op(15'h0000, 6'b100101, 6'b100010);

        // R10 collision: write lands with a delayed clear
        do_write(32'h0000_0006);
        op_valid = 1'b1; imm = 15'h0002;
        @(negedge clk);
        op_valid = 1'b0;
        check("R5 ie dropped A", 32'(a_ie), 32'h0);
        wr_en = 1'b1; wr_data = 32'h0000_0002;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 write wins A", 32'(a_ie), 32'h1);
        check("R10 write wins B", 32'(b_ie), 32'h1);
        ma = 32'h2; mb = 32'h2; mc = 32'h2;
        do_op(15'h0000, 6'b100101, 6'b100010);

        // R6 user mode: carry-only allowed, others fault; R7 no-MMU clears only below 14
        do_write(32'hA5A5_7FFF);
        do_op(15'h0004, 6'b100101, 6'b100010);
        do_op(15'h0002, 6'b100101, 6'b100010);
        do_op(15'h0000, 6'b100101, 6'b100010);
        do_op(15'h4000, 6'b100101, 6'b100010);
        check("R7 user bit kept B", 32'(mb[14]), 32'h1);
        do_op(15'h0000, 6'b100101, 6'b100010);
        do_op(15'h0010, 6'b100111, 6'b100010);
        do_op(15'h0010, 6'b100101, 6'b000010);

        // R1 reset during a pending clear
        do_write(32'h0000_3FFF);
        op_valid = 1'b1; imm = 15'h3FFF;
        @(negedge clk);
        op_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-op A", {a_rv, a_ex, a_cy, a_ie, 3'b0, a_cd}, 32'h0);
        ma = '0; mb = '0; mc = '0;
        do_op(15'h0000, 6'b100101, 6'b100010);

        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 25) begin
                logic [31:0] d = $urandom;
                if ($urandom_range(0, 2) != 0) d[14] = 1'b0;
                do_write(d);
            end else begin
                logic [14:0] m = 15'($urandom);
                logic [5:0] mj = 6'b100101, fn = 6'b100010;
                if (r < 40) m = 15'h0004;
                if (r > 92) mj = 6'($urandom);
                if (r > 96) fn = 6'($urandom);
                do_op(m, mj, fn);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule